// File: doc/BRIEF.md
# Short-Pulse Button Event Catcher

This block turns presses on a set of independent push-buttons (two by default, one per player) into clean single-cycle events in the system clock domain. A press may be much shorter than one clock period and may fall anywhere within it. Each button edge sets a flag flop that is clocked by the button itself. That flag crosses into the clock domain through a synchronizer. A small per-channel controller then issues a one-clock event and clears the flag only after the event has been issued and the button has been released.

The release side has a bounce filter. The synchronized button level must stay low for a programmable number of clocks before the release is accepted. Bounce during the press is absorbed by the flag, which is already set. A consuming state machine sees the events of all channels in the same cycle, so it can choose its next state from whichever player pressed. An active-high asynchronous reset clears every captured flag and every piece of channel state.

Top module: `btn_event_catcher`

## Requirements
- R1: A press on btn_i[k] that is high for less than one clock period, at any phase of the period, produces exactly one event on event_o[k].
- R2: Every event on event_o[k] is exactly one clock cycle wide.
- R3: With SYNC_STAGES = 2, a short press that starts mid-cycle makes event_o[k] high during the cycle that follows the third rising clock edge after the press starts, and low before it.
- R4: After an event has been issued and the button has been released, a later press produces a new event.
- R5: A press held for many cycles produces one event only. The flag is cleared only after the event has been issued and the release has been accepted.
- R6: A release is accepted only after the synchronized button level has been low for FILTER_CYCLES consecutive clocks. Bounce pulses of at least one clock during release therefore yield no extra event. FILTER_CYCLES = 0 accepts the release as soon as the synchronized level is low.
- R7: A second press that arrives while an earlier press on the same channel is still pending merges into the pending event. It is not queued.
- R8: rst_i is active high and asynchronous. It clears pending presses, so a press caught before reset yields no event after reset, and event_o is all zeros during reset.
- R9: The channels are independent and identical. Simultaneous presses on btn_i[0] and btn_i[1] give events in the same cycle, on the same bit index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock |
| rst_i | input | 1 | Asynchronous reset, active high |
| btn_i | input | NUM_CH | Raw button levels, active high, one per channel |
| event_o | output | NUM_CH | One-cycle press events, bit k for button k |

## Verification
A flag that is never cleared shows up at the ports as a missing event on the next press. A flag cleared too early, or a broken release filter, shows up as a second event from one held or bouncing press, within about ten clocks of the release. A controller stuck outside its idle state leaves later presses silent. A wrong pulse generator widens an event beyond one cycle or moves it off the third edge after the press. The directed tests therefore count events per press and check the exact cycle of each event.

// File: rtl/btn_evt_pkg.sv
package btn_evt_pkg;

    // Per-channel controller states
    typedef enum logic [1:0] {
        CH_IDLE  = 2'd0,   // waiting for a synchronized flag
        CH_HELD  = 2'd1,   // event issued, waiting for accepted release
        CH_CLEAR = 2'd2,   // clear pulse applied to the capture flop
        CH_DRAIN = 2'd3    // waiting for the synchronized flag to drop
    } ch_state_e;

    // Synchronized view of one channel
    typedef struct packed {
        logic flag;   // captured press flag, synchronized
        logic level;  // raw button level, synchronized
    } ch_sync_t;

    // Counter width able to hold the value n (at least one bit)
    function automatic int cnt_width(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/btn_capture.sv
// Flag flop clocked by the button itself: any rising button edge sets it,
// however short the pulse. Cleared asynchronously by reset or controller.
module btn_capture (
    input  logic btn_i,
    input  logic rst_i,
    input  logic clr_i,
    output logic flag_o
);
    logic clr_any;
    assign clr_any = rst_i | clr_i;

    always_ff @(posedge btn_i or posedge clr_any) begin
        if (clr_any) flag_o <= 1'b0;
        else         flag_o <= 1'b1;
    end
endmodule

// File: rtl/btn_sync.sv
// Multi-stage synchronizer into the clock domain.
module btn_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] chain_q;

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) chain_q <= '0;
        else       chain_q <= {chain_q[STAGES-2:0], d_i};
    end

    assign q_o = chain_q[STAGES-1];
endmodule

// File: rtl/btn_release_filter.sv
// Accepts a release only after the level has stayed low long enough.
module btn_release_filter
    import btn_evt_pkg::*;
#(
    parameter int FILTER_CYCLES = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic level_i,
    output logic released_o
);
    generate
        if (FILTER_CYCLES == 0) begin : g_bypass
            assign released_o = ~level_i;
        end else begin : g_count
            localparam int CW = cnt_width(FILTER_CYCLES);
            localparam logic [CW-1:0] LIMIT = CW'(FILTER_CYCLES);
            logic [CW-1:0] quiet_q;

            always_ff @(posedge clk_i or posedge rst_i) begin
                if (rst_i)                quiet_q <= '0;
                else if (level_i)         quiet_q <= '0;
                else if (quiet_q != LIMIT) quiet_q <= quiet_q + 1'b1;
            end

            assign released_o = ~level_i & (quiet_q == LIMIT);

            // Release implies the level was already low on the previous clock
            assert_release_after_quiet_R6 : assert property (
                @(posedge clk_i) disable iff (rst_i)
                released_o |-> !$past(level_i))
                else $error("release accepted without a quiet period");
        end
    endgenerate
endmodule

// File: rtl/btn_channel.sv
// One button channel: capture, synchronize, filter, pulse and clear control.
module btn_channel
    import btn_evt_pkg::*;
#(
    parameter int SYNC_STAGES   = 2,
    parameter int FILTER_CYCLES = 4
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic btn_i,
    output logic event_o
);
    logic      flag_raw;
    logic      clr_q;
    logic      released;
    ch_sync_t  sync_s;
    ch_state_e state_q, state_d;
    logic      event_q, event_d;
    logic      clr_d;

    btn_capture u_capture (
        .btn_i  (btn_i),
        .rst_i  (rst_i),
        .clr_i  (clr_q),
        .flag_o (flag_raw)
    );

    btn_sync #(.STAGES(SYNC_STAGES)) u_sync_flag (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (flag_raw),
        .q_o   (sync_s.flag)
    );

    btn_sync #(.STAGES(SYNC_STAGES)) u_sync_level (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .d_i   (btn_i),
        .q_o   (sync_s.level)
    );

    btn_release_filter #(.FILTER_CYCLES(FILTER_CYCLES)) u_filter (
        .clk_i      (clk_i),
        .rst_i      (rst_i),
        .level_i    (sync_s.level),
        .released_o (released)
    );

    always_comb begin
        state_d = state_q;
        event_d = 1'b0;
        clr_d   = 1'b0;
        unique case (state_q)
            CH_IDLE: begin
                if (sync_s.flag) begin
                    event_d = 1'b1;
                    state_d = CH_HELD;
                end
            end
            CH_HELD: begin
                if (released) begin
                    clr_d   = 1'b1;
                    state_d = CH_CLEAR;
                end
            end
            CH_CLEAR: state_d = CH_DRAIN;
            CH_DRAIN: begin
                if (!sync_s.flag) state_d = CH_IDLE;
            end
            default: state_d = CH_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or posedge rst_i) begin
        if (rst_i) begin
            state_q <= CH_IDLE;
            event_q <= 1'b0;
            clr_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            event_q <= event_d;
            clr_q   <= clr_d;
        end
    end

    assign event_o = event_q;

    assert_single_cycle_event_R2 : assert property (
        @(posedge clk_i) disable iff (rst_i)
        event_q |=> !event_q)
        else $error("event wider than one cycle");

    assert_event_from_flag_R1 : assert property (
        @(posedge clk_i) disable iff (rst_i)
        event_q |-> $past(sync_s.flag))
        else $error("event without a synchronized flag");

    assert_clear_after_release_R5 : assert property (
        @(posedge clk_i) disable iff (rst_i)
        clr_q |-> $past(released))
        else $error("flag cleared before release accepted");

    assert_clear_after_event_R5 : assert property (
        @(posedge clk_i) disable iff (rst_i)
        $rose(clr_q) |-> !event_q)
        else $error("clear overlaps the event cycle");
endmodule

// File: rtl/btn_event_catcher.sv
module btn_event_catcher #(
    parameter int NUM_CH        = 2,
    parameter int SYNC_STAGES   = 2,
    parameter int FILTER_CYCLES = 4
) (
    input  logic              clk_i,
    input  logic              rst_i,
    input  logic [NUM_CH-1:0] btn_i,
    output logic [NUM_CH-1:0] event_o
);
    generate
        for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
            btn_channel #(
                .SYNC_STAGES   (SYNC_STAGES),
                .FILTER_CYCLES (FILTER_CYCLES)
            ) u_ch (
                .clk_i   (clk_i),
                .rst_i   (rst_i),
                .btn_i   (btn_i[k]),
                .event_o (event_o[k])
            );
        end
    endgenerate

    assert_quiet_after_reset_R8 : assert property (
        @(posedge clk_i)
        $past(rst_i) |-> (event_o == '0))
        else $error("event right after reset");
endmodule

// File: tb/btn_event_catcher_tb_top.sv
`timescale 1ns/1ps
module btn_event_catcher_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 2;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] btn = '0;
    logic [NCH-1:0] evt;

    int n_checks = 0;
    int n_fail   = 0;
    int ev_cnt0  = 0;
    int ev_cnt1  = 0;
    int wide_cnt = 0;
    logic [NCH-1:0] evt_prev = '0;
    bit done = 0;

    btn_event_catcher #(.NUM_CH(NCH), .SYNC_STAGES(2), .FILTER_CYCLES(4)) dut_i (
        .clk_i   (clk),
        .rst_i   (rst),
        .btn_i   (btn),
        .event_o (evt)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Event counting and width monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst) begin
            if (evt[0]) ev_cnt0++;
            if (evt[1]) ev_cnt1++;
            if ((evt & evt_prev) != '0) wide_cnt++;
        end
        evt_prev = rst ? '0 : evt;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_counts();
        ev_cnt0 = 0; ev_cnt1 = 0; wide_cnt = 0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(posedge clk);
    endtask

    task automatic test_reset();
        rst = 1'b1;
        idle(3);
        @(negedge clk);
        chk("R8 reset output", int'(evt), 0);
        rst = 1'b0;
        idle(5);
    endtask

    task automatic test_short_latency();
        clear_counts();
        @(posedge clk); #3; btn[0] = 1'b1; #1; btn[0] = 1'b0;
        @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R3 no event before third edge", int'(evt[0]), 0);
        @(posedge clk); @(negedge clk);
        chk("R3 event after third edge", int'(evt[0]), 1);
        @(negedge clk);
        chk("R2 event dropped next cycle", int'(evt[0]), 0);
        idle(20);
        chk("R1 one event from short press", ev_cnt0, 1);
        chk("R9 other channel silent", ev_cnt1, 0);
        chk("R2 no wide events", wide_cnt, 0);
    endtask

    task automatic test_near_edge();
        clear_counts();
        @(posedge clk); #(CLK_PERIOD - 1); btn[1] = 1'b1; #0.5; btn[1] = 1'b0;
        idle(20);
        chk("R1 sub-cycle press near edge", ev_cnt1, 1);
        chk("R9 other channel silent", ev_cnt0, 0);
    endtask

    task automatic test_rearm();
        clear_counts();
        @(posedge clk); #4; btn[0] = 1'b1; #2; btn[0] = 1'b0;
        idle(20);
        @(posedge clk); #6; btn[0] = 1'b1; #2; btn[0] = 1'b0;
        idle(20);
        chk("R4 second separated press re-arms", ev_cnt0, 2);
    endtask

    task automatic test_long_hold();
        clear_counts();
        @(posedge clk); #2; btn[0] = 1'b1;
        idle(40);
        #2; btn[0] = 1'b0;
        idle(20);
        chk("R5 long hold gives one event", ev_cnt0, 1);
    endtask

    task automatic test_bounce();
        clear_counts();
        @(posedge clk); #1;
        for (int i = 0; i < 4; i++) begin
            btn[1] = 1'b1; #3; btn[1] = 1'b0; #3;
        end
        btn[1] = 1'b1;
        idle(10);
        #1;
        for (int i = 0; i < 3; i++) begin
            btn[1] = 1'b0; #15; btn[1] = 1'b1; #12;
        end
        btn[1] = 1'b0;
        idle(25);
        chk("R6 bounce yields one event", ev_cnt1, 1);
        chk("R2 no wide events under bounce", wide_cnt, 0);
    endtask

    task automatic test_merge();
        clear_counts();
        @(posedge clk); #3; btn[0] = 1'b1; #1; btn[0] = 1'b0;
        #10; btn[0] = 1'b1; #1; btn[0] = 1'b0;
        idle(20);
        chk("R7 pending presses merge", ev_cnt0, 1);
    endtask

    task automatic test_both();
        clear_counts();
        @(posedge clk); #5; btn = 2'b11; #1; btn = 2'b00;
        @(posedge clk); @(posedge clk); @(posedge clk); @(negedge clk);
        chk("R9 both events same cycle", int'(evt), 3);
        idle(20);
        chk("R9 channel 0 count", ev_cnt0, 1);
        chk("R9 channel 1 count", ev_cnt1, 1);
    endtask

    task automatic test_async_reset();
        clear_counts();
        @(posedge clk); #3; btn[1] = 1'b1; #1; btn[1] = 1'b0;
        #2; rst = 1'b1;
        #13; rst = 1'b0;
        idle(20);
        chk("R8 reset discards pending press", ev_cnt1, 0);
        @(posedge clk); #3; btn[1] = 1'b1; #1; btn[1] = 1'b0;
        idle(20);
        chk("R8 channel works after reset", ev_cnt1, 1);
    endtask

    initial begin
        test_reset();
        test_short_latency();
        test_near_edge();
        test_rearm();
        test_long_hold();
        test_bounce();
        test_merge();
        test_both();
        test_async_reset();
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule